// File: doc/BRIEF.md
# Shock Buffer Pointer Manager

This block keeps the pointers of a circular external-memory buffer used to ride out mechanical shocks in an audio player. Three pointers move around the ring. The write pointer advances as the encoder stores data. The read pointer advances as the decoder fetches data. The good-data pointer marks the end of the data that upstream logic has confirmed as sound. The block flags a full ring and an exhausted ring. It reports the amount of confirmed data still unread, in coarse units, and it services the two pointer-clear commands.

A small decode state machine lets the read pointer advance only while decoding is enabled and confirmed data remains. It has three states:
- `DEC_IDLE`: decoding is off.
- `DEC_RUN`: the decoder is fetching.
- `DEC_STARVED`: decoding is enabled but no confirmed data remains.

The transitions are `IDLE->RUN` and `IDLE->STARVED` when enable rises (the choice depends on whether the ring is exhausted), `RUN->STARVED` when the read pointer meets the good-data pointer, `STARVED->RUN` when confirmed data appears again, and `RUN/STARVED->IDLE` when enable falls. The return to `DEC_RUN` needs no command.

A second two-state machine holds a disturbance flag. Its states are `DST_CLEAR` and `DST_HELD`. It moves `CLEAR->HELD` when the selected sampling rule detects an error on the external error input, and `HELD->CLEAR` on either pointer-clear command.

Top module: `shock_buf_ptr_mgr`

## Requirements
- R1: After reset, all three pointers are zero, overflow and disturb are low, and dec_active is low.
- R2: An accepted write step advances wr_ptr by one, wrapping modulo the ring size. The ring size is set by mem_sel: 00 gives 2^BASE_AW words, 01 gives 2^(BASE_AW+2), 10 gives 2^(BASE_AW+3) and 11 gives 2^(BASE_AW+4). A write step is ignored while overflow is high.
- R3: A read step advances rd_ptr by one modulo the ring size, but only while dec_active is high and empty is low. Otherwise it is ignored.
- R4: confirm copies the current wr_ptr into good_ptr. wr_clr zeroes wr_ptr and good_ptr. rd_clr zeroes rd_ptr. A clear wins over a step or confirm in the same cycle. mem_sel is changed only together with both clears.
- R5: overflow rises on the edge where an accepted write makes wr_ptr equal to rd_ptr. It then stays high until wr_clr or rd_clr.
- R6: empty is high exactly when rd_ptr equals good_ptr.
- R7: residual equals ((good_ptr - rd_ptr) modulo the ring size) shifted right by RES_SHIFT.
- R8: The decode state machine follows the transitions listed above, updating one cycle after its inputs change. dec_active is high only in DEC_RUN.
- R9: With err_mode 00, disturb sets on a falling edge of frame_clk, seen between two clock samples, while err_flag is low. With err_mode 01, it sets on a rising edge of frame_clk while err_flag is low.
- R10: With err_mode 10, disturb sets in any cycle where err_flag is low. With err_mode 11, it sets in any cycle where err_flag is high.
- R11: disturb stays high until wr_clr or rd_clr. A clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_sel | input | 2 | Ring size select |
| wr_step | input | 1 | Request to advance the write pointer |
| confirm | input | 1 | Mark data up to the write pointer as good |
| rd_step | input | 1 | Request to advance the read pointer |
| dec_en | input | 1 | Decode enable |
| wr_clr | input | 1 | Clear the write and good-data pointers |
| rd_clr | input | 1 | Clear the read pointer |
| err_mode | input | 2 | Disturbance sampling rule |
| err_flag | input | 1 | External error indication |
| frame_clk | input | 1 | Frame clock, sampled synchronously |
| wr_ptr | output | BASE_AW+4 | Write pointer |
| rd_ptr | output | BASE_AW+4 | Read pointer |
| good_ptr | output | BASE_AW+4 | End of confirmed data |
| overflow | output | 1 | Ring full flag |
| empty | output | 1 | No confirmed data left to read |
| residual | output | BASE_AW+4-RES_SHIFT | Unread confirmed data, in coarse units |
| disturb | output | 1 | Latched disturbance flag |
| dec_active | output | 1 | Decode state machine is in DEC_RUN |

## Verification
Several directed patterns each target one behaviour:
- Filling the smallest ring with no reads drives the write pointer onto the read pointer. This shows that overflow rises on the lap edge and not one write early, and that later writes are then frozen.
- Enabling decode on an empty ring and then confirming data tells the automatic STARVED-to-RUN restart apart from a design that needs a new enable.
- Walking frame_clk through each of the four err_mode values tells edge rules apart from level rules, and error-low rules apart from error-high rules.

Seeded random traffic runs on every ring size. It mixes reads, writes, confirms and rare clears, and it separates correct wrap masks and residual shifts from ones that are off by a size step.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        DEC_IDLE    = 2'd0,
        DEC_RUN     = 2'd1,
        DEC_STARVED = 2'd2
    } dec_state_t;

    typedef enum logic {
        DST_CLEAR = 1'b0,
        DST_HELD  = 1'b1
    } dst_state_t;

    typedef enum logic [1:0] {
        ERR_FALL_LOW = 2'd0,
        ERR_RISE_LOW = 2'd1,
        ERR_LVL_LOW  = 2'd2,
        ERR_LVL_HIGH = 2'd3
    } err_mode_t;

endpackage

// File: rtl/sbp_ptrs.sv
module sbp_ptrs #(
    parameter int BASE_AW = 18,
    localparam int ADDR_W = BASE_AW + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mem_sel,
    input  logic              wr_step,
    input  logic              confirm,
    input  logic              rd_go,
    input  logic              wr_clr,
    input  logic              rd_clr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] good_ptr,
    output logic [ADDR_W-1:0] mask,
    output logic              overflow,
    output logic              empty
);

    localparam logic [ADDR_W-1:0] MASK_S = {4'b0000, {BASE_AW{1'b1}}};
    localparam logic [ADDR_W-1:0] MASK_M = {2'b00, {(BASE_AW+2){1'b1}}};
    localparam logic [ADDR_W-1:0] MASK_L = {1'b0, {(BASE_AW+3){1'b1}}};
    localparam logic [ADDR_W-1:0] MASK_X = {ADDR_W{1'b1}};

    logic              wr_acc;
    logic [ADDR_W-1:0] wr_inc;
    logic [ADDR_W-1:0] rd_inc;

    always_comb begin
        unique case (mem_sel)
            2'd0:    mask = MASK_S;
            2'd1:    mask = MASK_M;
            2'd2:    mask = MASK_L;
            default: mask = MASK_X;
        endcase
    end

    assign wr_acc = wr_step && !overflow;
    assign wr_inc = (wr_ptr + 1'b1) & mask;
    assign rd_inc = (rd_ptr + 1'b1) & mask;
    assign empty  = (rd_ptr == good_ptr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            good_ptr <= '0;
        end else if (wr_clr) begin
            wr_ptr   <= '0;
            good_ptr <= '0;
        end else begin
            if (wr_acc)
                wr_ptr <= wr_inc;
            if (confirm)
                good_ptr <= wr_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (rd_clr)
            rd_ptr <= '0;
        else if (rd_go)
            rd_ptr <= rd_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (wr_clr || rd_clr)
            overflow <= 1'b0;
        else if (wr_acc && (wr_inc == rd_ptr))
            overflow <= 1'b1;
    end

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !wr_clr && !rd_clr |=> overflow);

    // R2
    wr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !wr_clr |=> $stable(wr_ptr));

    // R4
    wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (wr_ptr == '0) && (good_ptr == '0));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !rd_clr |=> $stable(rd_ptr));

endmodule

// File: rtl/sbp_residual.sv
module sbp_residual #(
    parameter int ADDR_W    = 22,
    parameter int RES_SHIFT = 6,
    localparam int RES_W    = ADDR_W - RES_SHIFT
) (
    input  logic [ADDR_W-1:0] good_ptr,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic [ADDR_W-1:0] mask,
    output logic [RES_W-1:0]  residual
);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] span_sh;

    assign span     = (good_ptr - rd_ptr) & mask;
    assign span_sh  = span >> RES_SHIFT;
    assign residual = span_sh[RES_W-1:0];

endmodule

// File: rtl/sbp_dec_fsm.sv
module sbp_dec_fsm
    import sbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dec_en,
    input  logic empty,
    input  logic rd_step,
    output logic dec_active,
    output logic rd_go
);

    dec_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= DEC_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DEC_IDLE: begin
                if (dec_en)
                    state_nx = empty ? DEC_STARVED : DEC_RUN;
            end
            DEC_RUN: begin
                if (!dec_en)
                    state_nx = DEC_IDLE;
                else if (empty)
                    state_nx = DEC_STARVED;
            end
            DEC_STARVED: begin
                if (!dec_en)
                    state_nx = DEC_IDLE;
                else if (!empty)
                    state_nx = DEC_RUN;
            end
            default: state_nx = DEC_IDLE;
        endcase
    end

    always_comb begin
        dec_active = (state == DEC_RUN);
        rd_go      = rd_step && dec_active && !empty;
    end

    // R8
    dec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> !dec_active);

    // R8
    dec_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DEC_STARVED) && dec_en && !empty |=> dec_active);

endmodule

// File: rtl/sbp_disturb.sv
module sbp_disturb
    import sbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] err_mode,
    input  logic       err_flag,
    input  logic       frame_clk,
    input  logic       clr,
    output logic       disturb
);

    dst_state_t state, state_nx;
    logic       fclk_q;
    logic       hit;

    always_ff @(posedge clk) begin
        if (!rst_n)
            fclk_q <= 1'b0;
        else
            fclk_q <= frame_clk;
    end

    always_comb begin
        unique case (err_mode_t'(err_mode))
            ERR_FALL_LOW: hit = fclk_q && !frame_clk && !err_flag;
            ERR_RISE_LOW: hit = !fclk_q && frame_clk && !err_flag;
            ERR_LVL_LOW:  hit = !err_flag;
            default:      hit = err_flag;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= DST_CLEAR;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DST_CLEAR: if (!clr && hit) state_nx = DST_HELD;
            DST_HELD:  if (clr)         state_nx = DST_CLEAR;
            default:   state_nx = DST_CLEAR;
        endcase
    end

    assign disturb = (state == DST_HELD);

    // R11
    dist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disturb && !clr |=> disturb);

    // R11
    dist_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !disturb);

endmodule

// File: rtl/shock_buf_ptr_mgr.sv
module shock_buf_ptr_mgr #(
    parameter int BASE_AW   = 18,
    parameter int RES_SHIFT = 6,
    localparam int ADDR_W   = BASE_AW + 4,
    localparam int RES_W    = ADDR_W - RES_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mem_sel,
    input  logic              wr_step,
    input  logic              confirm,
    input  logic              rd_step,
    input  logic              dec_en,
    input  logic              wr_clr,
    input  logic              rd_clr,
    input  logic [1:0]        err_mode,
    input  logic              err_flag,
    input  logic              frame_clk,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] good_ptr,
    output logic              overflow,
    output logic              empty,
    output logic [RES_W-1:0]  residual,
    output logic              disturb,
    output logic              dec_active
);

    logic [ADDR_W-1:0] mask;
    logic              rd_go;

    sbp_ptrs #(.BASE_AW(BASE_AW)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_sel  (mem_sel),
        .wr_step  (wr_step),
        .confirm  (confirm),
        .rd_go    (rd_go),
        .wr_clr   (wr_clr),
        .rd_clr   (rd_clr),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .good_ptr (good_ptr),
        .mask     (mask),
        .overflow (overflow),
        .empty    (empty)
    );

    sbp_residual #(.ADDR_W(ADDR_W), .RES_SHIFT(RES_SHIFT)) u_res (
        .good_ptr (good_ptr),
        .rd_ptr   (rd_ptr),
        .mask     (mask),
        .residual (residual)
    );

    sbp_dec_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_en     (dec_en),
        .empty      (empty),
        .rd_step    (rd_step),
        .dec_active (dec_active),
        .rd_go      (rd_go)
    );

    sbp_disturb u_dst (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_mode  (err_mode),
        .err_flag  (err_flag),
        .frame_clk (frame_clk),
        .clr       (wr_clr || rd_clr),
        .disturb   (disturb)
    );

    // R6
    empty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (residual == '0));

endmodule

// File: tb/shock_buf_ptr_mgr_tb.sv
module shock_buf_ptr_mgr_tb;

    localparam int B  = 4;
    localparam int RS = 2;
    localparam int AW = B + 4;
    localparam int RW = AW - RS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mem_sel = 2'd0;
    logic          wr_step = 1'b0, confirm = 1'b0, rd_step = 1'b0, dec_en = 1'b0;
    logic          wr_clr = 1'b0, rd_clr = 1'b0;
    logic [1:0]    err_mode = 2'd2;
    logic          err_flag = 1'b1, frame_clk = 1'b0;
    logic [AW-1:0] wr_ptr, rd_ptr, good_ptr;
    logic          overflow, empty, disturb, dec_active;
    logic [RW-1:0] residual;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [AW-1:0] m_wa = '0, m_ra = '0, m_gp = '0;
    logic          m_ovf = 1'b0, m_dst = 1'b0, m_fq = 1'b0;
    int            m_st = 0;

    always #2 clk = ~clk;

    shock_buf_ptr_mgr #(.BASE_AW(B), .RES_SHIFT(RS)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .wr_step(wr_step),
        .confirm(confirm), .rd_step(rd_step), .dec_en(dec_en), .wr_clr(wr_clr),
        .rd_clr(rd_clr), .err_mode(err_mode), .err_flag(err_flag),
        .frame_clk(frame_clk), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .good_ptr(good_ptr), .overflow(overflow), .empty(empty),
        .residual(residual), .disturb(disturb), .dec_active(dec_active)
    );

    function automatic logic [AW-1:0] fn_mask(input logic [1:0] s);
        case (s)
            2'd0:    return 8'h0F;
            2'd1:    return 8'h3F;
            2'd2:    return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic fn_hit(input logic [1:0] md, input logic fq,
                                    input logic fk, input logic e);
        case (md)
            2'd0:    return fq && !fk && !e;
            2'd1:    return !fq && fk && !e;
            2'd2:    return !e;
            default: return e;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [AW-1:0] mk;
        logic [AW-1:0] span;
        mk   = fn_mask(mem_sel);
        span = (m_gp - m_ra) & mk;
        chk("R2 wr_ptr", int'(wr_ptr), int'(m_wa));
        chk("R3 rd_ptr", int'(rd_ptr), int'(m_ra));
        chk("R4 good_ptr", int'(good_ptr), int'(m_gp));
        chk("R5 overflow", int'(overflow), int'(m_ovf));
        chk("R6 empty", int'(empty), int'(m_ra == m_gp));
        chk("R7 residual", int'(residual), int'(span >> RS));
        chk("R8 dec_active", int'(dec_active), int'(m_st == 1));
        chk("R9 R10 R11 disturb", int'(disturb), int'(m_dst));
    endtask

    task automatic step(input logic [1:0] s, input logic w, input logic c,
                        input logic r, input logic de, input logic wc,
                        input logic rc, input logic [1:0] fm, input logic e,
                        input logic fk);
        logic [AW-1:0] mk, winc, n_wa, n_ra, n_gp;
        logic emp, wr_ok, rd_ok, n_ovf, n_dst;
        int n_st;
        mem_sel = s; wr_step = w; confirm = c; rd_step = r; dec_en = de;
        wr_clr = wc; rd_clr = rc; err_mode = fm; err_flag = e; frame_clk = fk;
        mk    = fn_mask(s);
        emp   = (m_ra == m_gp);
        wr_ok = w && !m_ovf;
        rd_ok = r && (m_st == 1) && !emp;
        winc  = (m_wa + 1'b1) & mk;
        n_wa = m_wa; n_gp = m_gp; n_ra = m_ra; n_ovf = m_ovf; n_dst = m_dst;
        if (wc) begin
            n_wa = '0; n_gp = '0;
        end else begin
            if (wr_ok) n_wa = winc;
            if (c) n_gp = m_wa;
        end
        if (rc) n_ra = '0;
        else if (rd_ok) n_ra = (m_ra + 1'b1) & mk;
        if (wc || rc) n_ovf = 1'b0;
        else if (wr_ok && winc == m_ra) n_ovf = 1'b1;
        if (wc || rc) n_dst = 1'b0;
        else if (fn_hit(fm, m_fq, fk, e)) n_dst = 1'b1;
        n_st = !de ? 0 : (emp ? 2 : 1);
        @(posedge clk);
        @(negedge clk);
        m_wa = n_wa; m_ra = n_ra; m_gp = n_gp; m_ovf = n_ovf;
        m_dst = n_dst; m_fq = fk; m_st = n_st;
        check_all();
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_ptr", int'(wr_ptr), 0);
        chk("R1 rd_ptr", int'(rd_ptr), 0);
        chk("R1 good_ptr", int'(good_ptr), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 disturb", int'(disturb), 0);
        chk("R1 dec_active", int'(dec_active), 0);

        // R5 / R2: fill the smallest ring with no reads
        for (int i = 0; i < 16; i++)
            step(2'd0, 1, 0, 0, 0, 0, 0, 2'd3, 0, 0);
        chk("R5 overflow after lap", int'(overflow), 1);
        chk("R2 wrap to zero", int'(wr_ptr), 0);
        step(2'd0, 1, 0, 0, 0, 0, 0, 2'd3, 0, 0);
        chk("R2 write ignored on overflow", int'(wr_ptr), 0);
        step(2'd0, 0, 0, 0, 0, 0, 1, 2'd3, 0, 0);
        chk("R5 cleared by rd_clr", int'(overflow), 0);

        // R8: enable on empty ring, then confirm data -> automatic restart
        step(2'd0, 0, 0, 0, 0, 1, 1, 2'd3, 0, 0);
        step(2'd0, 0, 0, 0, 1, 0, 0, 2'd3, 0, 0);
        step(2'd0, 1, 0, 0, 1, 0, 0, 2'd3, 0, 0);
        step(2'd0, 1, 1, 0, 1, 0, 0, 2'd3, 0, 0);
        chk("R8 still starved", int'(dec_active), 0);
        step(2'd0, 0, 0, 1, 1, 0, 0, 2'd3, 0, 0);
        chk("R8 restart to run", int'(dec_active), 1);
        step(2'd0, 0, 0, 1, 1, 0, 0, 2'd3, 0, 0);
        chk("R3 read advanced", int'(rd_ptr), 1);

        // R9 / R10 / R11: each sampling rule
        for (int md = 0; md < 4; md++) begin
            step(2'd0, 0, 0, 0, 0, 1, 1, 2'(md), 1, 0);
            for (int k = 0; k < 8; k++)
                step(2'd0, 0, 0, 0, 0, 0, 0, 2'(md), k[2], k[0]);
            step(2'd0, 0, 0, 0, 0, 1, 0, 2'(md), md[0], 1);
            chk("R11 clear wins", int'(disturb), 0);
        end

        // random traffic on every ring size
        for (int ph = 0; ph < 4; ph++) begin
            step(2'(ph), 0, 0, 0, 0, 1, 1, 2'(ph), 1, 0);
            for (int n = 0; n < 1500; n++)
                step(2'(ph), ($urandom % 4) != 0, ($urandom % 5) == 0,
                     ($urandom % 3) != 0, ($urandom % 50) != 0,
                     ($urandom % 97) == 0, ($urandom % 97) == 0,
                     2'((ph + n / 300) % 4), ($urandom % 3) != 0,
                     1'($urandom % 2));
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule